// File: doc/BRIEF.md
# Branch-and-Bound Unrooted Tree Enumerator

This engine walks the whole space of unrooted binary trees over `N_TAXA` labelled leaves in depth-first order. It starts from a three-leaf star. To go one level deeper it splits one edge of the current tree and attaches the next taxon there. A tree is held as an ordered list of edge entries, one list per depth. A child list is built from its parent in three parts. The entries before the split edge are copied unchanged. The three new edges follow. The entries after the split edge come last, each moved two places later. The copy moves four entries per clock.

Every split adds a cost, read from a small cost table that the host loads, to the running lower bound of the branch. The bound is checked against a global upper bound that the host supplies. A branch whose bound is not below that limit is dropped on the spot: it is never expanded and its siblings are tried next. Each complete tree that survives is streamed out, four entries per beat, under a valid/ready handshake, together with its bound. A one-cycle done pulse ends the walk.

Top module: `tree_enum_engine`

## Requirements
- R1: While reset is held, and after it is released until `start`, `out_valid`, `done` and `busy` are all low.
- R2: An edge entry is `{u, v}`, with `u` in the upper `VW` bits and `v` in the lower `VW` bits. Leaves are numbered 0..N_TAXA-1. The starting list is `{0,N_TAXA}`, `{1,N_TAXA}`, `{2,N_TAXA}`. Taxon k (k >= 3) is attached by splitting entry c = `{a,b}` using a new internal vertex h = N_TAXA+k-2. The new list is the entries before c, then `{a,h}`, `{h,b}`, `{k,h}`, then the entries that followed c, in their old order.
- R3: Trees are emitted in lexicographic order of their split choices. The choice for taxon 3 is the most significant, and each choice counts from entry 0 up to 2k-4.
- R4: A tree leaves in beats of four entries. Entry j is carried in lane j mod 4 of beat j/4, at bits `[lane*2*VW +: 2*VW]`. Every beat but the last has all lane-valid bits set. On the last beat, `out_last` is high and only the lanes that hold entries are valid (`4'b0001` for 8 taxa).
- R5: While `out_valid` is high and `out_ready` is low, the beat data, lane-valid bits and bound hold steady.
- R6: `out_bound` equals the sum of the cost entries `cost[k][c_k]` over the split choices of the tree, where a host write with `cost_we` stores `cost_data` at (`cost_taxon`, `cost_edge`).
- R7: A complete tree is emitted only if its bound is strictly less than `upper_bound`, and every such tree is emitted. With `upper_bound` = 0 no tree is emitted.
- R8: With all costs zero and `upper_bound` at its maximum, exactly (2N-5)!! trees are emitted (10,395 for 8 taxa).
- R9: After the last tree, `done` is high for exactly one cycle, never together with `out_valid`. `busy` then drops, and a new `start` repeats the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an enumeration when idle |
| upper_bound | input | BW | Global bound; a branch survives only if its bound is below this value |
| cost_we | input | 1 | Cost table write strobe |
| cost_taxon | input | TW | Cost write address: taxon being attached |
| cost_edge | input | EIW | Cost write address: index of the edge that is split |
| cost_data | input | CW | Cost write data |
| out_valid | output | 1 | A beat of a surviving tree is on the output |
| out_ready | input | 1 | The consumer accepts the beat |
| out_edges | output | 4*2*VW | Four edge entries of the current beat |
| out_lane_valid | output | 4 | Which lanes of the beat hold entries |
| out_last | output | 1 | Final beat of the tree |
| out_bound | output | BW | Lower bound of the tree being emitted |
| busy | output | 1 | Enumeration in progress |
| done | output | 1 | One-cycle pulse at the end of the walk |

## Verification
Two events can meet in the same cycle: delivery of the last beat of the final surviving tree, and the end of the whole walk. The bench runs one enumeration with the consumer stalling on a fixed pattern and a table of non-zero costs, so that pruning and back-pressure interleave. It judges the result with a scoreboard. Every tree it predicts must arrive in order with its bound before `done` appears. The tree count must match exactly, and `done` must never overlap a valid beat.

// File: rtl/tree_enum_pkg.sv
package tree_enum_pkg;
  localparam int LANES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_COPY,
    ST_EMIT,
    ST_DONE
  } tee_state_e;
endpackage

// File: rtl/tree_enum_splice.sv
// Builds one beat (four lanes) of a child edge list from its parent row.
module tree_enum_splice
  import tree_enum_pkg::*;
#(
  parameter int MAXE  = 13,
  parameter int VW    = 4,
  parameter int EIW   = 4,
  parameter int BEATW = 3
) (
  input  logic [2*VW-1:0]  src [MAXE],
  input  logic [EIW-1:0]   cut_idx,
  input  logic [EIW-1:0]   new_len,
  input  logic [BEATW-1:0] beat,
  input  logic [VW-1:0]    leaf_id,
  input  logic [VW-1:0]    hub_id,
  output logic [2*VW-1:0]  lane_data [LANES],
  output logic [LANES-1:0] lane_ok,
  output logic [EIW-1:0]   lane_idx [LANES]
);
  localparam int EW = 2 * VW;

  logic [EW-1:0] cut_edge;
  assign cut_edge = src[cut_idx];

  function automatic logic [EW-1:0] src_at(input int i);
    if (i >= 0 && i < MAXE) return src[i];
    return '0;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    int j;
    int c;
    assign j = int'(beat) * LANES + g;
    assign c = int'(cut_idx);

    always_comb begin
      lane_idx[g] = EIW'(j);
      lane_ok[g]  = (j < int'(new_len));
      if (j < c)            lane_data[g] = src_at(j);               // prefix
      else if (j == c)      lane_data[g] = {cut_edge[EW-1:VW], hub_id};
      else if (j == c + 1)  lane_data[g] = {hub_id, cut_edge[VW-1:0]};
      else if (j == c + 2)  lane_data[g] = {leaf_id, hub_id};
      else                  lane_data[g] = src_at(j - 2);           // suffix
    end
  end
endmodule

// File: rtl/tree_enum_bound.sv
// Cost table plus incremental bound and prune decision.
module tree_enum_bound #(
  parameter int N_TAXA = 8,
  parameter int MAXE   = 13,
  parameter int CW     = 6,
  parameter int BW     = 12,
  parameter int TW     = 3,
  parameter int EIW    = 4
) (
  input  logic           clk,
  input  logic           cost_we,
  input  logic [TW-1:0]  cost_taxon,
  input  logic [EIW-1:0] cost_edge,
  input  logic [CW-1:0]  cost_data,
  input  logic [TW-1:0]  rd_taxon,
  input  logic [EIW-1:0] rd_edge,
  input  logic [BW-1:0]  parent_bound,
  input  logic [BW-1:0]  upper_bound,
  output logic [BW-1:0]  child_bound,
  output logic           prune
);
  logic [CW-1:0] cost_mem [N_TAXA][MAXE];
  logic [CW-1:0] cost_rd;
  logic [BW:0]   sum;

  always_ff @(posedge clk) begin
    if (cost_we && int'(cost_taxon) < N_TAXA && int'(cost_edge) < MAXE)
      cost_mem[cost_taxon][cost_edge] <= cost_data;
  end

  always_comb begin
    if (int'(rd_taxon) < N_TAXA && int'(rd_edge) < MAXE) cost_rd = cost_mem[rd_taxon][rd_edge];
    else                                                 cost_rd = '0;
    sum         = {1'b0, parent_bound} + (BW+1)'(cost_rd);
    child_bound = sum[BW] ? '1 : sum[BW-1:0];
    prune       = (child_bound >= upper_bound);
  end
endmodule

// File: rtl/tree_enum_engine.sv
module tree_enum_engine
  import tree_enum_pkg::*;
#(
  parameter int N_TAXA = 8,
  parameter int CW     = 6,
  parameter int BW     = 12,
  localparam int MAXE  = 2 * N_TAXA - 3,
  localparam int VW    = $clog2(2 * N_TAXA - 2),
  localparam int EW    = 2 * VW,
  localparam int EIW   = $clog2(MAXE + 1),
  localparam int TW    = $clog2(N_TAXA)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [BW-1:0]         upper_bound,
  input  logic                  cost_we,
  input  logic [TW-1:0]         cost_taxon,
  input  logic [EIW-1:0]        cost_edge,
  input  logic [CW-1:0]         cost_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*EW-1:0]   out_edges,
  output logic [LANES-1:0]      out_lane_valid,
  output logic                  out_last,
  output logic [BW-1:0]         out_bound,
  output logic                  busy,
  output logic                  done
);
  localparam int FRAMES = N_TAXA - 3;
  localparam int LEVELS = N_TAXA - 2;
  localparam int DW     = $clog2(LEVELS);
  localparam int BEATW  = $clog2((MAXE + LANES - 1) / LANES + 1);

  // reset: asynchronous assert, synchronous release
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs_n, rs_meta} <= 2'b00;
    else        {rs_n, rs_meta} <= {rs_meta, 1'b1};
  end

  tee_state_e       state_q, state_n;
  logic [DW-1:0]    lvl_q, lvl_n;
  logic [EIW-1:0]   cut_q, cut_n;
  logic [BW-1:0]    bnd_q, bnd_n;
  logic [BEATW-1:0] beat_q, beat_n;

  // backtracking stack and per-depth edge lists
  logic [EIW-1:0] stk_next [FRAMES];
  logic [BW-1:0]  stk_bnd  [FRAMES];
  logic [EW-1:0]  tmem     [LEVELS][MAXE];

  logic           stk_we;
  logic [DW-1:0]  stk_widx;
  logic [EIW-1:0] stk_wnext;
  logic [BW-1:0]  stk_wbnd;
  logic [LANES-1:0] tm_we;
  logic [DW-1:0]  tm_row;
  logic [EIW-1:0] tm_idx  [LANES];
  logic [EW-1:0]  tm_data [LANES];

  logic [EIW-1:0] top_next, nedges, new_len;
  logic [BW-1:0]  top_bnd, child_bnd;
  logic           prune, copy_last, emit_last;
  logic [EW-1:0]  src_row [MAXE];
  logic [EW-1:0]  sp_data [LANES];
  logic [LANES-1:0] sp_ok;
  logic [EIW-1:0] sp_idx  [LANES];

  assign top_next  = stk_next[lvl_q];
  assign top_bnd   = stk_bnd[lvl_q];
  assign nedges    = EIW'(2 * int'(lvl_q) + 3);
  assign new_len   = nedges + EIW'(2);
  assign copy_last = ((int'(beat_q) + 1) * LANES >= int'(new_len));
  assign emit_last = ((int'(beat_q) + 1) * LANES >= MAXE);

  always_comb begin
    for (int i = 0; i < MAXE; i++) src_row[i] = tmem[lvl_q][i];
  end

  tree_enum_splice #(.MAXE(MAXE), .VW(VW), .EIW(EIW), .BEATW(BEATW)) u_splice (
    .src      (src_row),
    .cut_idx  (cut_q),
    .new_len  (new_len),
    .beat     (beat_q),
    .leaf_id  (VW'(int'(lvl_q) + 3)),
    .hub_id   (VW'(N_TAXA + int'(lvl_q) + 1)),
    .lane_data(sp_data),
    .lane_ok  (sp_ok),
    .lane_idx (sp_idx)
  );

  tree_enum_bound #(.N_TAXA(N_TAXA), .MAXE(MAXE), .CW(CW), .BW(BW), .TW(TW), .EIW(EIW)) u_bound (
    .clk         (clk),
    .cost_we     (cost_we),
    .cost_taxon  (cost_taxon),
    .cost_edge   (cost_edge),
    .cost_data   (cost_data),
    .rd_taxon    (TW'(int'(lvl_q) + 3)),
    .rd_edge     (top_next),
    .parent_bound(top_bnd),
    .upper_bound (upper_bound),
    .child_bound (child_bnd),
    .prune       (prune)
  );

  // next-state logic
  always_comb begin
    state_n   = state_q;
    lvl_n     = lvl_q;
    cut_n     = cut_q;
    bnd_n     = bnd_q;
    beat_n    = beat_q;
    stk_we    = 1'b0;
    stk_widx  = lvl_q;
    stk_wnext = top_next + EIW'(1);
    stk_wbnd  = top_bnd;
    tm_we     = '0;
    tm_row    = lvl_q + DW'(1);
    for (int g = 0; g < LANES; g++) begin
      tm_idx[g]  = sp_idx[g];
      tm_data[g] = sp_data[g];
    end
    case (state_q)
      ST_IDLE: if (start) begin
        tm_row = '0;
        for (int g = 0; g < LANES; g++) begin
          tm_we[g]   = (g < 3);
          tm_idx[g]  = EIW'(g);
          tm_data[g] = {VW'(g), VW'(N_TAXA)};
        end
        stk_we    = 1'b1;
        stk_widx  = '0;
        stk_wnext = '0;
        stk_wbnd  = '0;
        lvl_n     = '0;
        state_n   = ST_PICK;
      end
      ST_PICK: begin
        if (top_next == nedges) begin           // level exhausted: pop
          if (lvl_q == '0) state_n = ST_DONE;
          else             lvl_n   = lvl_q - DW'(1);
        end else begin
          stk_we = 1'b1;                         // advance choice
          if (!prune) begin
            cut_n   = top_next;
            bnd_n   = child_bnd;
            beat_n  = '0;
            state_n = ST_COPY;
          end
        end
      end
      ST_COPY: begin
        tm_we  = sp_ok;
        beat_n = beat_q + BEATW'(1);
        if (copy_last) begin
          beat_n = '0;
          if (int'(lvl_q) == FRAMES - 1) begin
            state_n = ST_EMIT;
          end else begin
            lvl_n     = lvl_q + DW'(1);
            stk_we    = 1'b1;                    // push new frame
            stk_widx  = lvl_q + DW'(1);
            stk_wnext = '0;
            stk_wbnd  = bnd_q;
            state_n   = ST_PICK;
          end
        end
      end
      ST_EMIT: if (out_ready) begin
        if (emit_last) begin
          beat_n  = '0;
          state_n = ST_PICK;
        end else begin
          beat_n = beat_q + BEATW'(1);
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      cut_q   <= '0;
      bnd_q   <= '0;
      beat_q  <= '0;
    end else begin
      state_q <= state_n;
      lvl_q   <= lvl_n;
      cut_q   <= cut_n;
      bnd_q   <= bnd_n;
      beat_q  <= beat_n;
    end
  end

  always_ff @(posedge clk) begin
    if (stk_we) begin
      stk_next[stk_widx] <= stk_wnext;
      stk_bnd[stk_widx]  <= stk_wbnd;
    end
    for (int g = 0; g < LANES; g++) begin
      if (tm_we[g]) tmem[tm_row][tm_idx[g]] <= tm_data[g];
    end
  end

  // output lanes read the deepest row directly
  always_comb begin
    for (int g = 0; g < LANES; g++) begin
      int idx;
      idx = int'(beat_q) * LANES + g;
      out_lane_valid[g] = (idx < MAXE);
      out_edges[g*EW +: EW] = (idx < MAXE) ? tmem[LEVELS-1][EIW'(idx)] : '0;
    end
  end

  assign out_valid = (state_q == ST_EMIT);
  assign out_last  = emit_last;
  assign out_bound = bnd_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/tree_enum_checker.sv
module tree_enum_checker #(
  parameter int EW    = 8,
  parameter int BW    = 12,
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*EW-1:0] out_edges,
  input logic [LANES-1:0]    out_lane_valid,
  input logic                out_last,
  input logic [BW-1:0]       out_bound,
  input logic                done
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_edges) && $stable(out_bound) && $stable(out_lane_valid)); // R5

  AST_FULL_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_lane_valid == {LANES{1'b1}}); // R4

  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lane_valid[0] && ((out_lane_valid & (out_lane_valid + LANES'(1))) == '0)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R9
endmodule

bind tree_enum_engine tree_enum_checker #(.EW(EW), .BW(BW), .LANES(tree_enum_pkg::LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_edges     (out_edges),
  .out_lane_valid(out_lane_valid),
  .out_last      (out_last),
  .out_bound     (out_bound),
  .done          (done)
);

// File: tb/tree_enum_engine_tb_top.sv
module tree_enum_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT    = 8;
  localparam int MAXE  = 2 * NT - 3;
  localparam int VW    = 4;
  localparam int EW    = 2 * VW;
  localparam int LN    = 4;
  localparam int BW    = 12;
  localparam int CW    = 6;
  localparam int TW    = 3;
  localparam int EIW   = 4;

  logic clk = 1'b0;
  logic rst_n, start, cost_we, out_ready;
  logic [BW-1:0] upper_bound;
  logic [TW-1:0] cost_taxon;
  logic [EIW-1:0] cost_edge;
  logic [CW-1:0] cost_data;
  logic out_valid, out_last, busy, done;
  logic [LN*EW-1:0] out_edges;
  logic [LN-1:0] out_lane_valid;
  logic [BW-1:0] out_bound;

  always #(CLK_PERIOD/2) clk = ~clk;

  tree_enum_engine #(.N_TAXA(NT), .CW(CW), .BW(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .upper_bound(upper_bound),
    .cost_we(cost_we), .cost_taxon(cost_taxon), .cost_edge(cost_edge), .cost_data(cost_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_edges(out_edges),
    .out_lane_valid(out_lane_valid), .out_last(out_last), .out_bound(out_bound),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  // model state
  logic [CW-1:0] cost_tab [NT][MAXE];
  int ch [NT];
  logic [EW-1:0] lst [MAXE];
  int len;
  logic [MAXE*EW-1:0] exp_tree_q [$];
  int exp_bnd_q [$];

  // monitor state
  bit stall_mode = 0;
  bit monitor_on = 0;
  bit done_seen  = 0;
  int trees_got  = 0;
  int cyc        = 0;
  int gbeat      = 0;
  logic [EW-1:0] got [MAXE];
  bit held = 0;
  logic [LN*EW-1:0] held_edges;
  logic [BW-1:0] held_bnd;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // R2 splice rule applied to lst, attaching taxon k at entry c
  task automatic attach(input int k, input int c);
    logic [VW-1:0] a, b, h;
    h = VW'(NT + k - 2);
    a = lst[c][EW-1:VW];
    b = lst[c][VW-1:0];
    for (int i = len - 1; i > c; i--) lst[i+2] = lst[i];
    lst[c]   = {a, h};
    lst[c+1] = {h, b};
    lst[c+2] = {VW'(k), h};
    len += 2;
  endtask

  // driver: scoreboard fill, lexicographic order of choices (R3), filter by bound (R7)
  task automatic plan_run(input int ub);
    bit fin;
    exp_tree_q.delete();
    exp_bnd_q.delete();
    for (int k = 0; k < NT; k++) ch[k] = 0;
    fin = 0;
    while (!fin) begin
      int bnd;
      logic [MAXE*EW-1:0] pk;
      len = 3;
      for (int i = 0; i < 3; i++) lst[i] = {VW'(i), VW'(NT)};
      bnd = 0;
      for (int k = 3; k < NT; k++) begin
        attach(k, ch[k]);
        bnd += int'(cost_tab[k][ch[k]]);
      end
      if (bnd < ub) begin
        for (int i = 0; i < MAXE; i++) pk[i*EW +: EW] = lst[i];
        exp_tree_q.push_back(pk);
        exp_bnd_q.push_back(bnd);
      end
      begin
        int k;
        k = NT - 1;
        fin = 1;
        while (k >= 3) begin
          ch[k]++;
          if (ch[k] < 2 * k - 3) begin fin = 0; break; end
          ch[k] = 0;
          k--;
        end
      end
    end
  endtask

  task automatic load_costs(input bit nonzero);
    for (int k = 0; k < NT; k++) begin
      for (int e = 0; e < MAXE; e++) begin
        cost_tab[k][e] = nonzero ? CW'((k * 3 + e * 5) % 7) : '0;
        @(negedge clk);
        cost_we    = 1'b1;
        cost_taxon = TW'(k);
        cost_edge  = EIW'(e);
        cost_data  = cost_tab[k][e];
      end
    end
    @(negedge clk);
    cost_we = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    bit rdy;
    cyc++;
    if (monitor_on) begin
      rdy = stall_mode ? ((cyc % 3) != 0) : 1'b1;
      out_ready = rdy;
      if (held && out_valid)   // R5 data held over a stalled beat
        chk(out_edges == held_edges && out_bound == held_bnd, "R5 stall hold", int'(out_bound), int'(held_bnd));
      held = out_valid && !rdy;
      held_edges = out_edges;
      held_bnd = out_bound;
      if (done) done_seen = 1;
      if (out_valid && rdy) begin
        for (int g = 0; g < LN; g++)
          if (gbeat * LN + g < MAXE) got[gbeat*LN+g] = out_edges[g*EW +: EW];
        if (out_last) begin
          logic [MAXE*EW-1:0] pk;
          for (int i = 0; i < MAXE; i++) pk[i*EW +: EW] = got[i];
          chk(out_lane_valid == 4'b0001 && gbeat == 3, "R4 last beat lanes", int'(out_lane_valid), 1);
          if (exp_tree_q.size() == 0) begin
            chk(0, "R7 unexpected tree", trees_got + 1, trees_got);
          end else begin
            logic [MAXE*EW-1:0] ep;
            int eb;
            ep = exp_tree_q.pop_front();
            eb = exp_bnd_q.pop_front();
            chk(pk == ep, "R2/R3 tree edge list", int'(pk[31:0]), int'(ep[31:0]));
            chk(int'(out_bound) == eb, "R6 tree bound", int'(out_bound), eb);
          end
          trees_got++;
          gbeat = 0;
        end else begin
          gbeat++;
        end
      end
    end
  end

  task automatic run_case(input int ub, input bit stall, input string tag);
    int n_exp;
    plan_run(ub);
    n_exp = exp_tree_q.size();
    trees_got = 0;
    done_seen = 0;
    gbeat = 0;
    held = 0;
    stall_mode = stall;
    @(negedge clk);
    upper_bound = BW'(ub);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy during walk", int'(busy), 1);
    while (!done_seen) @(negedge clk);
    chk(trees_got == n_exp, {tag, " tree count"}, trees_got, n_exp);
    chk(exp_tree_q.size() == 0, "R7 all predicted trees seen", exp_tree_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 done single cycle then idle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9: watchdog expired, got 0 expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    cost_we = 1'b0;
    cost_taxon = '0;
    cost_edge = '0;
    cost_data = '0;
    upper_bound = '0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 0 && done == 0 && busy == 0, "R1 reset outputs", int'({out_valid, done, busy}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 0 && done == 0 && busy == 0, "R1 idle after release", int'({out_valid, done, busy}), 0);
    monitor_on = 1;

    load_costs(0);
    run_case(0, 0, "R7 zero bound");
    chk(trees_got == 0, "R7 nothing emitted at bound 0", trees_got, 0);

    run_case(4095, 0, "R8 full walk");
    chk(trees_got == 10395, "R8 (2N-5)!! trees", trees_got, 10395);

    load_costs(1);
    run_case(13, 1, "R7 pruned walk with stalls");
    chk(trees_got > 0, "R6 pruned walk emits trees", trees_got, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule